// File: doc/BRIEF.md
# Internal Data Memory Address Unit

This unit resolves every operand access that an 8-bit control CPU makes to its on-chip data space. Each access arrives with a kind (direct, indirect, register, bit, push or pop), an 8-bit address or a 3-bit register number, the current two-bit register-bank select and write data. The unit sends the access to one of three places: the lower 128-byte RAM, the optional upper 128-byte RAM, or an external special-function-register (SFR) port.

One address byte can mean different storage depending on how it is used. The upper half of the address range reaches SFRs when used directly, but reaches the upper RAM when it comes through a pointer register or the stack. Single-bit operations are carried out as a read-modify-write on the containing byte, whether that byte is in RAM or in an SFR. The unit also keeps the stack pointer and moves it for pushes and pops.

Read results are registered. A request presented in one cycle shows its byte and selected bit on the outputs after the next rising clock edge. Writes to RAM take effect at that same edge.

Top module: `idata_addr_unit`

## Requirements
- R1: A direct access with address 00H–7FH reads or writes lower RAM at that address. With address 80H–FFH it goes only to the SFR port: `sfr_addr` equals the address, and `sfr_wr` (write) or `sfr_rd` (read) is raised. RAM is left unchanged.
- R2: An indirect access uses as its address the byte held in R0 (`acc_reg[0]`=0) or R1 (`acc_reg[0]`=1) of the selected bank. It reaches lower RAM below 80H and upper RAM from 80H up, and never strobes the SFR port.
- R3: A register access to Rn (n = `acc_reg`) reaches lower RAM address `bank_sel`×8 + n.
- R4: A bit access with bit address b in 00H–7FH reaches RAM byte 20H + b[6:3], bit b[2:0]. A bit write changes only that bit of that byte.
- R5: A bit access with b in 80H–FFH reaches SFR byte {b[7:3],000}, bit b[2:0]. A bit write reads that byte through `sfr_rdata` and writes it back through `sfr_wdata` in the same cycle, with only that bit replaced.
- R6: After reset the stack pointer is 07H. A push (kind 4) first increments the pointer and then writes `wr_data` at the new value. A pop (kind 5) reads the byte at the pointer and then decrements it. Stack accesses reach upper RAM above 7FH and never strobe the SFR port.
- R7: When built without upper RAM (`HAS_UPPER`=0), writes to addresses 80H–FFH through indirect or stack access are discarded, and reads there return 00H.
- R8: A read request in the cycle before a rising edge yields `rd_valid`=1, the addressed byte on `rd_data` and, for bit accesses, the selected bit on `rd_bit`, all after that edge. A write request leaves `rd_valid` at 0.
- R9: During and right after reset, `sp` is 07H, `rd_valid` is 0 and neither SFR strobe is active while no request is presented.
- Kind encoding: 0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop. `acc_we` selects write for kinds 0–3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_kind | input | 3 | Access kind (0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop) |
| acc_we | input | 1 | Write for direct, indirect, register and bit kinds |
| acc_addr | input | 8 | Direct byte address or bit address |
| acc_reg | input | 3 | Register number; bit 0 picks the pointer for indirect access |
| bank_sel | input | 2 | Current register bank |
| wr_data | input | 8 | Byte write data, also push data |
| wr_bit | input | 1 | Bit write value |
| sfr_addr | output | 8 | SFR byte address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, combinational on `sfr_addr` |
| rd_valid | output | 1 | Registered read result valid |
| rd_data | output | 8 | Registered read byte |
| rd_bit | output | 1 | Registered selected bit |
| sp | output | 8 | Current stack pointer |

## Verification
The bench targets address aliasing. It writes SFR 90H directly and upper RAM 90H indirectly, then reads both back. A decoder that ignores the access kind would let one write overwrite the other. Register accesses are issued under one bank and read back directly under another, which exposes a wrong bank×8 offset. Bit writes in the RAM window and in SFR space are compared against whole-byte readback: a wrong byte or bit index, or a plain write instead of read-modify-write, corrupts the neighbouring bits. The stack is driven across the 7FH/80H boundary on a full build and on a build without upper RAM. Post-increment pushes or pops, or stack traffic leaking onto the SFR port, show up as wrong popped values or strobes.

// File: rtl/idata_pkg.sv
package idata_pkg;

  typedef enum logic [2:0] {
    ACC_DIRECT   = 3'd0,
    ACC_INDIRECT = 3'd1,
    ACC_REGISTER = 3'd2,
    ACC_BIT      = 3'd3,
    ACC_PUSH     = 3'd4,
    ACC_POP      = 3'd5
  } acc_kind_e;

  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam logic [3:0]  BIT_BASE = 4'h2;  // bit window starts at 20H
  localparam logic [7:0]  SP_RESET = 8'h07;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              to_sfr;
    logic              bit_op;
    logic [2:0]        bit_pos;
  } route_t;

endpackage

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned AW  = 7,
  parameter int unsigned DW  = 8,
  parameter int unsigned NRD = 1
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [DW-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/idata_stack.sv
module idata_stack
  import idata_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp
);
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;

  always_comb begin
    sp_en = push | pop;
    sp_d  = sp_q;
    if (push)     sp_d = sp_q + 8'd1;
    else if (pop) sp_d = sp_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RESET;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  assert_push_preinc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + 8'd1);
  assert_pop_postdec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_q == $past(sp_q) - 8'd1);
  assert_sp_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q));

endmodule

// File: rtl/idata_route.sv
module idata_route
  import idata_pkg::*;
(
  input  acc_kind_e         kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_reg,
  input  logic [1:0]        bank_sel,
  input  logic [ADDR_W-1:0] sp,
  input  logic [DATA_W-1:0] ptr_val,
  output logic [ADDR_W-1:0] ptr_addr,
  output route_t            rt
);
  // pointer register R0/R1 of the current bank
  assign ptr_addr = {3'b000, bank_sel, 2'b00, acc_reg[0]};

  always_comb begin
    rt         = '0;
    rt.addr    = acc_addr;
    unique case (kind)
      ACC_DIRECT: begin
        rt.addr   = acc_addr;
        rt.to_sfr = acc_addr[7];
      end
      ACC_INDIRECT: rt.addr = ptr_val;
      ACC_REGISTER: rt.addr = {3'b000, bank_sel, acc_reg};
      ACC_BIT: begin
        rt.bit_op  = 1'b1;
        rt.bit_pos = acc_addr[2:0];
        rt.to_sfr  = acc_addr[7];
        rt.addr    = acc_addr[7] ? {acc_addr[7:3], 3'b000}
                                 : {BIT_BASE, acc_addr[6:3]};
      end
      ACC_PUSH: rt.addr = sp + 8'd1;
      ACC_POP:  rt.addr = sp;
      default:  rt.addr = acc_addr;
    endcase
  end

endmodule

// File: rtl/idata_addr_unit.sv
module idata_addr_unit
  import idata_pkg::*;
#(
  parameter bit HAS_UPPER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic [2:0] acc_kind,
  input  logic       acc_we,
  input  logic [7:0] acc_addr,
  input  logic [2:0] acc_reg,
  input  logic [1:0] bank_sel,
  input  logic [7:0] wr_data,
  input  logic       wr_bit,
  output logic [7:0] sfr_addr,
  output logic       sfr_rd,
  output logic       sfr_wr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_bit,
  output logic [7:0] sp
);
  localparam int unsigned HALF_AW = ADDR_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  acc_kind_e         kind;
  route_t            rt;
  logic [ADDR_W-1:0] ptr_addr;
  logic [DATA_W-1:0] ptr_val, lower_rd, upper_rd, byte_in, byte_mod, wbyte;
  logic              write_op, is_push, is_pop;
  logic              lower_we, upper_we, rd_take;
  logic [1:0][HALF_AW-1:0] lower_raddr;
  logic [1:0][DATA_W-1:0]  lower_rdata;

  assign kind    = acc_kind_e'(acc_kind);
  assign is_push = acc_valid && (kind == ACC_PUSH);
  assign is_pop  = acc_valid && (kind == ACC_POP);

  idata_stack u_stack (
    .clk  (clk),
    .rst_n(rst_sync),
    .push (is_push),
    .pop  (is_pop),
    .sp   (sp)
  );

  idata_route u_route (
    .kind    (kind),
    .acc_addr(acc_addr),
    .acc_reg (acc_reg),
    .bank_sel(bank_sel),
    .sp      (sp),
    .ptr_val (ptr_val),
    .ptr_addr(ptr_addr),
    .rt      (rt)
  );

  // lower RAM: port 0 fetches the pointer, port 1 the operand
  assign lower_raddr[0] = ptr_addr[HALF_AW-1:0];
  assign lower_raddr[1] = rt.addr[HALF_AW-1:0];
  assign ptr_val        = lower_rdata[0];
  assign lower_rd       = lower_rdata[1];

  idata_ram #(.AW(HALF_AW), .DW(DATA_W), .NRD(2)) u_lower (
    .clk  (clk),
    .we   (lower_we),
    .waddr(rt.addr[HALF_AW-1:0]),
    .wdata(wbyte),
    .raddr(lower_raddr),
    .rdata(lower_rdata)
  );

  if (HAS_UPPER) begin : g_upper
    logic [0:0][HALF_AW-1:0] up_raddr;
    logic [0:0][DATA_W-1:0]  up_rdata;
    assign up_raddr[0] = rt.addr[HALF_AW-1:0];
    assign upper_rd    = up_rdata[0];
    idata_ram #(.AW(HALF_AW), .DW(DATA_W), .NRD(1)) u_upper (
      .clk  (clk),
      .we   (upper_we),
      .waddr(rt.addr[HALF_AW-1:0]),
      .wdata(wbyte),
      .raddr(up_raddr),
      .rdata(up_rdata)
    );
  end else begin : g_no_upper
    assign upper_rd = '0;
  end

  // operand byte and read-modify-write
  always_comb begin
    if (rt.to_sfr)        byte_in = sfr_rdata;
    else if (rt.addr[7])  byte_in = upper_rd;
    else                  byte_in = lower_rd;
    byte_mod             = byte_in;
    byte_mod[rt.bit_pos] = wr_bit;
    wbyte    = rt.bit_op ? byte_mod : wr_data;
    write_op = acc_valid && (is_push || (acc_we && kind != ACC_POP));
    lower_we = write_op && !rt.to_sfr && !rt.addr[7];
    upper_we = write_op && !rt.to_sfr &&  rt.addr[7];
    rd_take  = acc_valid && !write_op;
  end

  assign sfr_addr  = rt.addr;
  assign sfr_wdata = wbyte;
  assign sfr_wr    = write_op && rt.to_sfr;
  assign sfr_rd    = acc_valid && rt.to_sfr && (!acc_we || rt.bit_op);

  // registered read result
  logic       rd_valid_q, rd_bit_q;
  logic [7:0] rd_data_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_bit_q   <= 1'b0;
    end else begin
      rd_valid_q <= rd_take;
      if (rd_take) begin
        rd_data_q <= byte_in;
        rd_bit_q  <= byte_in[rt.bit_pos];
      end
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_bit   = rd_bit_q;

  assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0({sfr_wr, lower_we, upper_we}));
  assert_indirect_no_sfr_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    (acc_valid && (kind == ACC_INDIRECT || kind == ACC_REGISTER)) |-> !(sfr_rd || sfr_wr));
  assert_sfr_bit_aligned_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    (acc_valid && kind == ACC_BIT && (sfr_rd || sfr_wr)) |-> sfr_addr[2:0] == 3'b000);
  assert_stack_no_sfr_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (is_push || is_pop) |-> !(sfr_rd || sfr_wr));
  assert_rd_after_req_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    rd_valid_q |-> $past(acc_valid));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    !acc_valid |-> !(sfr_rd || sfr_wr));

endmodule

// File: tb/test_idata_addr_unit.sv
module test_idata_addr_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc_valid, acc_we, wr_bit;
  logic [2:0] acc_kind, acc_reg;
  logic [7:0] acc_addr, wr_data;
  logic [1:0] bank_sel;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata, rd_data, sp;
  logic       sfr_rd, sfr_wr, rd_valid, rd_bit;
  logic [7:0] n_sfr_addr, n_sfr_wdata, n_rd_data, n_sp;
  logic       n_sfr_rd, n_sfr_wr, n_rd_valid, n_rd_bit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic strobe_seen;

  logic [7:0] sfr_mem [128];

  always #2 clk = ~clk;

  idata_addr_unit #(.HAS_UPPER(1'b1)) i_idata_addr_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_reg(acc_reg), .bank_sel(bank_sel),
    .wr_data(wr_data), .wr_bit(wr_bit), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit), .sp(sp));

  idata_addr_unit #(.HAS_UPPER(1'b0)) i_idata_addr_unit_noup (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_reg(acc_reg), .bank_sel(bank_sel),
    .wr_data(wr_data), .wr_bit(wr_bit), .sfr_addr(n_sfr_addr), .sfr_rd(n_sfr_rd),
    .sfr_wr(n_sfr_wr), .sfr_wdata(n_sfr_wdata), .sfr_rdata(8'h00),
    .rd_valid(n_rd_valid), .rd_data(n_rd_data), .rd_bit(n_rd_bit), .sp(n_sp));

  // simple SFR file model: combinational read, clocked write
  assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_wr) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one access: driven after a falling edge, taken at the next rising edge
  task automatic op(input logic [2:0] k, input logic we, input logic [7:0] a,
                    input logic [2:0] r, input logic [7:0] d, input logic b);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_we = we; acc_addr = a;
    acc_reg = r; wr_data = d; wr_bit = b;
    #1 strobe_seen = sfr_rd | sfr_wr;
    @(posedge clk);
    #1 acc_valid = 1'b0; acc_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 sp", sp, 8'h07);
    chk("R9 rd_valid", {7'd0, rd_valid}, 8'h00);
    chk("R9 strobes", {6'd0, sfr_rd, sfr_wr}, 8'h00);
  endtask

  task automatic t_direct;
    op(3'd0, 1'b1, 8'h35, 3'd0, 8'hA5, 1'b0);
    chk("R8 write no rd_valid", {7'd0, rd_valid}, 8'h00);
    op(3'd0, 1'b0, 8'h35, 3'd0, 8'h00, 1'b0);
    chk("R8 rd_valid", {7'd0, rd_valid}, 8'h01);
    chk("R1 lower direct", rd_data, 8'hA5);
    op(3'd0, 1'b1, 8'h10, 3'd0, 8'h11, 1'b0);
    op(3'd0, 1'b1, 8'h90, 3'd0, 8'h3C, 1'b0);
    chk("R1 sfr write strobe", {7'd0, strobe_seen}, 8'h01);
    chk("R1 sfr written", sfr_mem[7'h10], 8'h3C);
    op(3'd0, 1'b0, 8'h10, 3'd0, 8'h00, 1'b0);
    chk("R1 lower 10H untouched", rd_data, 8'h11);
  endtask

  task automatic t_register;
    bank_sel = 2'd2;
    op(3'd2, 1'b1, 8'h00, 3'd5, 8'h77, 1'b0);
    bank_sel = 2'd0;
    op(3'd0, 1'b0, 8'h15, 3'd0, 8'h00, 1'b0);
    chk("R3 bank2 R5 at 15H", rd_data, 8'h77);
  endtask

  task automatic t_indirect;
    bank_sel = 2'd1;
    op(3'd2, 1'b1, 8'h00, 3'd1, 8'h90, 1'b0);
    op(3'd1, 1'b1, 8'h00, 3'd1, 8'h5A, 1'b0);
    chk("R2 indirect no strobe", {7'd0, strobe_seen}, 8'h00);
    op(3'd1, 1'b0, 8'h00, 3'd1, 8'h00, 1'b0);
    chk("R2 upper via R1", rd_data, 8'h5A);
    chk("R7 absent upper reads zero", n_rd_data, 8'h00);
    chk("R2 sfr 90H kept", sfr_mem[7'h10], 8'h3C);
    op(3'd0, 1'b0, 8'h90, 3'd0, 8'h00, 1'b0);
    chk("R1 direct 90H is sfr", rd_data, 8'h3C);
    op(3'd2, 1'b1, 8'h00, 3'd0, 8'h35, 1'b0);
    op(3'd1, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0);
    chk("R2 lower via R0", rd_data, 8'hA5);
    bank_sel = 2'd0;
  endtask

  task automatic t_bit_ram;
    op(3'd0, 1'b1, 8'h2A, 3'd0, 8'h81, 1'b0);
    op(3'd3, 1'b1, 8'h53, 3'd0, 8'h00, 1'b1);
    op(3'd0, 1'b0, 8'h2A, 3'd0, 8'h00, 1'b0);
    chk("R4 bit 53H sets 2AH.3", rd_data, 8'h89);
    op(3'd3, 1'b0, 8'h53, 3'd0, 8'h00, 1'b0);
    chk("R4 bit read 53H", {7'd0, rd_bit}, 8'h01);
    op(3'd3, 1'b0, 8'h52, 3'd0, 8'h00, 1'b0);
    chk("R4 bit read 52H", {7'd0, rd_bit}, 8'h00);
  endtask

  task automatic t_bit_sfr;
    op(3'd0, 1'b1, 8'hA8, 3'd0, 8'hF0, 1'b0);
    op(3'd3, 1'b1, 8'hAA, 3'd0, 8'h00, 1'b1);
    chk("R5 sfr bit set", sfr_mem[7'h28], 8'hF4);
    op(3'd3, 1'b1, 8'hAF, 3'd0, 8'h00, 1'b0);
    chk("R5 sfr bit clear", sfr_mem[7'h28], 8'h74);
    op(3'd3, 1'b0, 8'hAC, 3'd0, 8'h00, 1'b0);
    chk("R5 sfr bit read", {7'd0, rd_bit}, 8'h01);
  endtask

  task automatic t_stack;
    op(3'd4, 1'b0, 8'h00, 3'd0, 8'h11, 1'b0);
    chk("R6 push sp", sp, 8'h08);
    op(3'd0, 1'b0, 8'h08, 3'd0, 8'h00, 1'b0);
    chk("R6 pushed at 08H", rd_data, 8'h11);
    op(3'd5, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0);
    chk("R6 pop data", rd_data, 8'h11);
    chk("R6 pop sp", sp, 8'h07);
    for (int i = 0; i < 120; i++) op(3'd4, 1'b0, 8'h00, 3'd0, 8'(i), 1'b0);
    chk("R6 sp at 7FH", sp, 8'h7F);
    op(3'd4, 1'b0, 8'h00, 3'd0, 8'hC3, 1'b0);
    chk("R6 push no sfr strobe", {7'd0, strobe_seen}, 8'h00);
    chk("R6 sp at 80H", sp, 8'h80);
    op(3'd5, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0);
    chk("R6 pop from upper", rd_data, 8'hC3);
    chk("R7 pop absent upper", n_rd_data, 8'h00);
    op(3'd5, 1'b0, 8'h00, 3'd0, 8'h00, 1'b0);
    chk("R6 pop 7FH", rd_data, 8'd119);
    chk("R7 lower still kept", n_rd_data, 8'd119);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) sfr_mem[i] = 8'h00;
    rst_n = 1'b0; acc_valid = 1'b0; acc_kind = 3'd0; acc_we = 1'b0;
    acc_addr = 8'h00; acc_reg = 3'd0; bank_sel = 2'd0; wr_data = 8'h00;
    wr_bit = 1'b0; strobe_seen = 1'b0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 t_reset();
    t_direct();
    t_register();
    t_indirect();
    t_bit_ram();
    t_bit_sfr();
    t_stack();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule